// File: doc/BRIEF.md
# Transfer Coprocessor Control and Status Registers

This block is the host-facing register front end of a small data-transfer coprocessor. A CPU reaches it over a byte-wide synchronous register bus with an address, a read strobe, a write strobe, write data and registered read data. Through three registers, software can:

- open the coprocessor's program RAM for loading;
- place an entry address;
- have that address copied into the coprocessor's program counter;
- start and stop execution;
- take the coprocessor's error and stop events as one shared interrupt.

The core side gets a run level, a RAM write enable and a one-cycle program-counter load strobe carrying the entry address. The RUN and LOAD controls exclude each other. They are held as one three-state machine:

- `ST_IDLE`: both controls are 0.
- `ST_LOAD`: program RAM writes are open.
- `ST_RUN`: the coprocessor executes.

Its transitions:

- `T_IDLE_LOAD`: a control write with the load bit set, taken from IDLE.
- `T_IDLE_RUN`: a control write with the run bit set and the load bit clear, taken from IDLE with no stop event.
- `T_LOAD_IDLE`: a control write with the load bit clear.
- `T_RUN_IDLE_SW`: a control write with the run bit clear.
- `T_RUN_IDLE_HW`: a stop event, which has priority over any write.

Register map:

- Address 0 is control.
- Address 1 is status.
- Address 2 is the write-only entry pointer.

Top module: `xcp_regs`

## Requirements
- R1: After reset, control, status and pointer hold 00h, and `core_run`, `core_ram_we_en`, `pc_load` and `irq_out` are 0.
- R2: Control bits are: bit 0 run, bit 1 init, bit 2 load, bit 3 stop-interrupt enable, bit 4 error-interrupt enable. Bits 7:5 always read 0.
- R3: A control write is judged against the run/load values held before it. It can set load only while run is 0, and it can set run only while load is 0. Clearing either bit is always accepted. Writing both bits set from IDLE gives load=1 and run=0.
- R4: `core_ram_we_en` equals the load bit and `core_run` equals the run bit. The two are never 1 together.
- R5: When `evt_stop` is 1 in a cycle, the stop flag (status bit 0) is set at that edge and run is cleared at that edge. The stop event wins over a run-setting write in the same cycle.
- R6: When `evt_error` is 1 while run is 1, the error flag (status bit 1) is set. An error event while run is 0 leaves the flag unchanged.
- R7: A status read returns {6'b0, error, stop} and clears both flags. A flag set in the same cycle as the read survives, and the read returns the value from before that cycle. Writes to status are ignored.
- R8: `irq_out` is 1 exactly when `irq_mask` is 0 and at least one of these holds: the error flag and bit 4 are both 1, or the stop flag and bit 3 are both 1.
- R9: The pointer is write-only and reads as 00h. When the init bit goes from 0 to 1, `pc_load` is 1 for exactly the one cycle after the write edge, with `pc_value` equal to the pointer. The init bit keeps the written value.
- R10: `bus_rdata` is registered. It is valid the cycle after the edge that samples `bus_rd`, and it holds its value otherwise. Address 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_error | input | 1 | Error event from the core |
| evt_stop | input | 1 | Stop event from the core |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks |
| irq_out | output | 1 | Shared interrupt request |
| core_run | output | 1 | Run level to the core |
| core_ram_we_en | output | 1 | Program RAM write enable |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_value | output | 8 | Entry address for the program counter |

## Verification
Every result is due one edge after its stimulus:

- A write or event sampled at edge k shows on `core_run`, `core_ram_we_en`, the flags and the readback after edge k.
- Read data for a strobe sampled at edge k appears after edge k.
- `pc_load` is high only between edge k and edge k+1 of the INIT write.
- `irq_out` follows `irq_mask` in the same cycle.

The bench drives every input on the falling edge and samples on the next falling edge, half a period after the edge that owns the result. For the same-cycle cases (read against flag set, run write against stop event), it raises both inputs on the same falling edge.

// File: rtl/xcp_pkg.sv
package xcp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

    localparam int BIT_RUN    = 0;
    localparam int BIT_INIT   = 1;
    localparam int BIT_LOAD   = 2;
    localparam int BIT_STOPEN = 3;
    localparam int BIT_ERREN  = 4;

    localparam int FLG_STOP  = 0;
    localparam int FLG_ERR   = 1;
    localparam int NUM_FLAGS = 2;

    localparam logic [1:0] A_CTL  = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_PTR  = 2'd2;

endpackage

// File: rtl/xcp_run_fsm.sv
module xcp_run_fsm
    import xcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       req_load,
    input  logic       req_run,
    input  logic       stop_evt,
    output run_state_e state_o,
    output logic       run_o,
    output logic       load_o
);

    run_state_e state_q;
    run_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: interlocks use the held state, i.e. pre-write values
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctl_wr && req_load) begin
                    state_d = ST_LOAD;                 // T_IDLE_LOAD
                end else if (ctl_wr && req_run && !stop_evt) begin
                    state_d = ST_RUN;                  // T_IDLE_RUN
                end
            end
            ST_LOAD: begin
                if (ctl_wr && !req_load) begin
                    state_d = ST_IDLE;                 // T_LOAD_IDLE
                end
            end
            ST_RUN: begin
                if (stop_evt) begin
                    state_d = ST_IDLE;                 // T_RUN_IDLE_HW
                end else if (ctl_wr && !req_run) begin
                    state_d = ST_IDLE;                 // T_RUN_IDLE_SW
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run_o  = 1'b0;
        load_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: load_o = 1'b1;
            ST_RUN:  run_o  = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/xcp_flags.sv
module xcp_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set_i[g]) begin
                flag_q <= 1'b1;          // a set wins over a clearing read
            end else if (clr_i) begin
                flag_q <= 1'b0;
            end
        end
        assign flag_o[g] = flag_q;
    end

endmodule

// File: rtl/xcp_entry.sv
module xcp_entry #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_wr,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  logic             init_bit,
    output logic             pc_load,
    output logic [PTR_W-1:0] pc_value
);

    logic [PTR_W-1:0] ptr_q;
    logic             init_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            init_prev_q <= 1'b0;
        end else begin
            if (ptr_wr) begin
                ptr_q <= ptr_wdata;
            end
            init_prev_q <= init_bit;
        end
    end

    assign pc_load  = init_bit && !init_prev_q;
    assign pc_value = ptr_q;

endmodule

// File: rtl/xcp_regs.sv
module xcp_regs
    import xcp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_error,
    input  logic              evt_stop,
    input  logic              irq_mask,
    output logic              irq_out,
    output logic              core_run,
    output logic              core_ram_we_en,
    output logic              pc_load,
    output logic [PTR_W-1:0]  pc_value
);

    localparam logic [ADDR_W-1:0] AD_CTL  = ADDR_W'(A_CTL);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_PTR  = ADDR_W'(A_PTR);

    logic wr_ctl, wr_ptr, rd_stat;
    logic err_en_q, stop_en_q, init_q;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [DATA_W-1:0]    rd_mux;
    logic [DATA_W-1:0]    rdata_q;
    run_state_e           run_state;

    assign wr_ctl  = bus_wr && (bus_addr == AD_CTL);
    assign wr_ptr  = bus_wr && (bus_addr == AD_PTR);
    assign rd_stat = bus_rd && (bus_addr == AD_STAT);

    xcp_run_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (wr_ctl),
        .req_load (bus_wdata[BIT_LOAD]),
        .req_run  (bus_wdata[BIT_RUN]),
        .stop_evt (evt_stop),
        .state_o  (run_state),
        .run_o    (core_run),
        .load_o   (core_ram_we_en)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_STOP] = evt_stop;
        flag_set[FLG_ERR]  = evt_error && (run_state == ST_RUN);
    end

    xcp_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (rd_stat),
        .flag_o (flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_en_q  <= 1'b0;
            stop_en_q <= 1'b0;
            init_q    <= 1'b0;
        end else if (wr_ctl) begin
            err_en_q  <= bus_wdata[BIT_ERREN];
            stop_en_q <= bus_wdata[BIT_STOPEN];
            init_q    <= bus_wdata[BIT_INIT];
        end
    end

    xcp_entry #(.PTR_W(PTR_W)) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_wr    (wr_ptr),
        .ptr_wdata (bus_wdata[PTR_W-1:0]),
        .init_bit  (init_q),
        .pc_load   (pc_load),
        .pc_value  (pc_value)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == AD_CTL) begin
            rd_mux[BIT_RUN]    = core_run;
            rd_mux[BIT_INIT]   = init_q;
            rd_mux[BIT_LOAD]   = core_ram_we_en;
            rd_mux[BIT_STOPEN] = stop_en_q;
            rd_mux[BIT_ERREN]  = err_en_q;
        end else if (bus_addr == AD_STAT) begin
            rd_mux[NUM_FLAGS-1:0] = flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_out   = !irq_mask && ((flags[FLG_ERR]  && err_en_q) ||
                                     (flags[FLG_STOP] && stop_en_q));

endmodule

// File: rtl/xcp_regs_chk.sv
module xcp_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_rd,
    input logic       evt_error,
    input logic       evt_stop,
    input logic       irq_mask,
    input logic       irq_out,
    input logic       core_run,
    input logic       core_ram_we_en,
    input logic       pc_load,
    input logic [1:0] flags
);

    // R4
    a_r4_run_load_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_run && core_ram_we_en));

    // R3
    a_r3_no_load_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        core_ram_we_en |=> !core_run);

    // R5
    a_r5_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stop |=> (!core_run && flags[0]));

    // R6
    a_r6_err_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_error && core_run) |=> flags[1]);

    // R7
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1 && !evt_stop && !evt_error) |=> (flags == 2'b00));

    // R8
    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq_out);

    // R9
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

endmodule

bind xcp_regs xcp_regs_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_rd         (bus_rd),
    .evt_error      (evt_error),
    .evt_stop       (evt_stop),
    .irq_mask       (irq_mask),
    .irq_out        (irq_out),
    .core_run       (core_run),
    .core_ram_we_en (core_ram_we_en),
    .pc_load        (pc_load),
    .flags          (flags)
);

// File: tb/xcp_regs_tb.sv
`timescale 1ns/1ps
module xcp_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       evt_error = 1'b0;
    logic       evt_stop = 1'b0;
    logic       irq_mask = 1'b0;
    logic       irq_out;
    logic       core_run;
    logic       core_ram_we_en;
    logic       pc_load;
    logic [7:0] pc_value;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    xcp_regs u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_rd         (bus_rd),
        .bus_wr         (bus_wr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .evt_error      (evt_error),
        .evt_stop       (evt_stop),
        .irq_mask       (irq_mask),
        .irq_out        (irq_out),
        .core_run       (core_run),
        .core_ram_we_en (core_ram_we_en),
        .pc_load        (pc_load),
        .pc_value       (pc_value)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive on falling edge; the action is sampled by the next rising edge;
    // return at the falling edge after it, with inputs released.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_stop();
        evt_stop = 1'b1;
        @(negedge clk);
        evt_stop = 1'b0;
    endtask

    task automatic pulse_err();
        evt_error = 1'b1;
        @(negedge clk);
        evt_error = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 run", {7'b0, core_run}, 8'h00);
        chk("R1 ram_we", {7'b0, core_ram_we_en}, 8'h00);
        chk("R1 pc_load", {7'b0, pc_load}, 8'h00);
        chk("R1 irq", {7'b0, irq_out}, 8'h00);
        chk("R1 pc_value", pc_value, 8'h00);
        rd(2'd0, v); chk("R1 ctl", v, 8'h00);
        rd(2'd1, v); chk("R1 status", v, 8'h00);
    endtask

    task automatic t_interlock();
        logic [7:0] v;
        wr(2'd0, 8'h04);
        chk("R4 ram_we after load", {7'b0, core_ram_we_en}, 8'h01);
        rd(2'd0, v); chk("R2 ctl load", v, 8'h04);
        wr(2'd0, 8'h05);
        chk("R3 run rejected while load", {7'b0, core_run}, 8'h00);
        rd(2'd0, v); chk("R3 ctl still load", v, 8'h04);
        wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R3 run rejected, load cleared", v, 8'h00);
        wr(2'd0, 8'h01);
        chk("R4 core_run", {7'b0, core_run}, 8'h01);
        wr(2'd0, 8'h05);
        chk("R3 load rejected while run", {7'b0, core_ram_we_en}, 8'h00);
        rd(2'd0, v); chk("R3 ctl still run", v, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h05);
        rd(2'd0, v); chk("R3 both from idle gives load", v, 8'h04);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R2 reserved bits read 0", v, 8'h1E);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R2 cleared", v, 8'h00);
    endtask

    task automatic t_stop();
        logic [7:0] v;
        wr(2'd0, 8'h01);
        pulse_stop();
        chk("R5 stop clears run", {7'b0, core_run}, 8'h00);
        rd(2'd1, v); chk("R5 stop flag", v, 8'h01);
        rd(2'd1, v); chk("R7 read cleared", v, 8'h00);
        // run write and stop event on the same edge: stop wins
        bus_addr = 2'd0; bus_wdata = 8'h01; bus_wr = 1'b1; evt_stop = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_stop = 1'b0;
        chk("R5 stop beats run write", {7'b0, core_run}, 8'h00);
        rd(2'd1, v);
    endtask

    task automatic t_error();
        logic [7:0] v;
        pulse_err();
        rd(2'd1, v); chk("R6 error ignored when idle", v, 8'h00);
        wr(2'd0, 8'h01);
        pulse_err();
        rd(2'd1, v); chk("R6 error while running", v, 8'h02);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_read_clear();
        logic [7:0] v;
        bus_addr = 2'd1; bus_rd = 1'b1; evt_stop = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; evt_stop = 1'b0;
        chk("R7 read returns pre-set value", bus_rdata, 8'h00);
        rd(2'd1, v); chk("R7 set wins over clear", v, 8'h01);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R7 status write ignored", v, 8'h00);
        rd(2'd3, v); chk("R10 address 3 reads 0", v, 8'h00);
        chk("R10 rdata holds", bus_rdata, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(2'd0, 8'h11);
        pulse_err();
        chk("R8 irq error", {7'b0, irq_out}, 8'h01);
        irq_mask = 1'b1; #1;
        chk("R8 irq masked", {7'b0, irq_out}, 8'h00);
        irq_mask = 1'b0; #1;
        chk("R8 irq unmasked", {7'b0, irq_out}, 8'h01);
        @(negedge clk);
        rd(2'd1, v); chk("R8 status", v, 8'h02);
        chk("R8 irq after clear", {7'b0, irq_out}, 8'h00);
        wr(2'd0, 8'h01);
        pulse_stop();
        chk("R8 stop without enable", {7'b0, irq_out}, 8'h00);
        rd(2'd1, v);
        wr(2'd0, 8'h09);
        pulse_stop();
        chk("R8 irq stop", {7'b0, irq_out}, 8'h01);
        rd(2'd1, v);
        chk("R8 irq after stop clear", {7'b0, irq_out}, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        wr(2'd2, 8'hA5);
        rd(2'd2, v); chk("R9 pointer reads 0", v, 8'h00);
        chk("R9 no pulse before init", {7'b0, pc_load}, 8'h00);
        wr(2'd0, 8'h02);
        chk("R9 pc_load pulse", {7'b0, pc_load}, 8'h01);
        chk("R9 pc_value", pc_value, 8'hA5);
        @(negedge clk);
        chk("R9 pulse one cycle", {7'b0, pc_load}, 8'h00);
        rd(2'd0, v); chk("R9 init bit holds", v, 8'h02);
        wr(2'd0, 8'h02);
        chk("R9 no pulse without edge", {7'b0, pc_load}, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h3C);
        wr(2'd0, 8'h02);
        chk("R9 second pulse value", pc_value, 8'h3C);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_interlock();
        t_reserved();
        t_stop();
        t_error();
        t_read_clear();
        t_irq();
        t_pointer();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule